// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches virtual-to-physical page mappings for a 32-bit address space. It holds 32 entries, any of which may map any virtual page. Each entry records a virtual page number, a physical page number, a permission field, an 8-bit process tag, a protect flag and a page-size code. The page-size code selects one of nine sizes between 4 KB and 256 MB. On each lookup the block compares the virtual address and the current process identifier against all entries at once. One clock edge later it presents the hit flag, the translated physical address, the permissions, the index of the entry used and a multi-hit flag.

Software or a table-walk agent fills the buffer through a write port that names the target entry directly. Two commands remove entries. A flush-all removes every unprotected entry. A single-entry invalidate removes one entry by index, whatever its protect flag. Page-table walking and fault generation are left to the surrounding logic.

Top module: `assoc_xlat_tlb`

## Requirements
- R1: After reset every entry is invalid, `rs_valid` and `rs_hit` are 0, and any lookup misses.
- R2: A lookup presented with `lk_valid` at clock edge k shows its result after edge k: `rs_valid` is 1 for exactly that cycle, and the result uses the table contents from before edge k.
- R3: An entry matches when it is valid and the virtual address bits above its page boundary equal its virtual page number. The physical address is then the entry's physical page bits above the boundary, joined with the virtual address bits below it.
- R4: Size code c (0 to 8) selects a page of 4 KB times 4^c, so the page offset is 12+2c bits wide. Code 0 is 4 KB and code 8 is 256 MB.
- R5: A write whose size code is 9 to 15 is ignored, and the target entry keeps its previous contents.
- R6: An entry whose process tag is 0 matches every process identifier. An entry with any other tag matches only a process identifier equal to that tag.
- R7: On a miss, `rs_hit`, `rs_multi`, `rs_paddr`, `rs_perm` and `rs_index` are all 0.
- R8: When more than one entry matches, `rs_multi` is 1, and the lowest-index matching entry supplies the address, the permissions and `rs_index`.
- R9: A flush-all invalidates every entry whose protect flag is clear and leaves every protected entry valid and unchanged.
- R10: A single-entry invalidate clears the indexed entry even when its protect flag is set.
- R11: Within one cycle, flush-all is applied first, then the single invalidate, then a legal write. A written entry is therefore valid after the edge, even when the same cycle carries an invalidate for it.
- R12: On a hit, `rs_index` gives the index of the entry that supplied the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | 8 | Current process identifier |
| wr_en | input | 1 | Load an entry |
| wr_index | input | 5 | Entry to load |
| wr_vpn | input | 20 | Virtual page number in 4 KB units |
| wr_ppn | input | 20 | Physical page number in 4 KB units |
| wr_size | input | 4 | Page-size code (0..8 legal) |
| wr_tid | input | 8 | Process tag (0 = global) |
| wr_perm | input | 6 | Permission bits |
| wr_prot | input | 1 | Protect against flush-all |
| inv_one | input | 1 | Invalidate the entry at inv_index |
| inv_index | input | 5 | Entry to invalidate |
| inv_all | input | 1 | Flush all unprotected entries |
| rs_valid | output | 1 | Lookup result present |
| rs_hit | output | 1 | Lookup hit |
| rs_multi | output | 1 | More than one entry matched |
| rs_index | output | 5 | Index of the entry used |
| rs_paddr | output | 32 | Translated physical address |
| rs_perm | output | 6 | Permissions of the entry used |

## Verification
The bound checker watches several invariants on every cycle. It checks that a result follows each request by one cycle, that the outputs are zeroed on a miss and that a multi-hit implies a hit. It also checks that the page offset passes through unchanged, that a legal write leaves its entry valid, and that a flush-all leaves only protected entries. Other behaviour can be shown only by the bench's directed scenarios, because each depends on a particular table content. These are address composition across all nine page sizes, process-tag matching for global and private entries, and the lowest-index choice on an overlap. They also include rejection of illegal size codes, single invalidates of protected entries and the same-cycle ordering of lookups, writes and invalidates.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W     = 32;
    localparam int PG_LSB   = 12;
    localparam int PN_W     = VA_W - PG_LSB;
    localparam int ENTRIES  = 32;
    localparam int IDX_W    = $clog2(ENTRIES);
    localparam int TID_W    = 8;
    localparam int PERM_W   = 6;
    localparam int CODE_W   = 4;
    localparam int MAX_CODE = 8;

    typedef struct packed {
        logic              valid;
        logic              prot;
        logic [TID_W-1:0]  tid;
        logic [PN_W-1:0]   vpn;
        logic [PN_W-1:0]   ppn;
        logic [PN_W-1:0]   keep;   // 1 = page-number bit takes part in the compare
        logic [PERM_W-1:0] perm;
    } entry_t;

    typedef entry_t [ENTRIES-1:0] table_t;

    typedef struct packed {
        table_t            ent;
        logic              rs_valid;
        logic              rs_hit;
        logic              rs_multi;
        logic [IDX_W-1:0]  rs_index;
        logic [VA_W-1:0]   rs_paddr;
        logic [PERM_W-1:0] rs_perm;
    } state_t;
endpackage

// File: rtl/tlb_size_decode.sv
module tlb_size_decode #(
    parameter int PN_W     = tlb_pkg::PN_W,
    parameter int CODE_W   = tlb_pkg::CODE_W,
    parameter int MAX_CODE = tlb_pkg::MAX_CODE
) (
    input  logic [CODE_W-1:0] code,
    output logic              legal,
    output logic [PN_W-1:0]   keep
);
    localparam int SH_W = CODE_W + 2;

    logic [SH_W-1:0] shift;

    assign legal = (code <= CODE_W'(MAX_CODE));
    assign shift = {1'b0, code, 1'b0};

    // each size step adds two offset bits, so page-number bit i is kept when i >= 2*code
    for (genvar i = 0; i < PN_W; i++) begin : g_keep
        assign keep[i] = (SH_W'(i) >= shift);
    end
endmodule

// File: rtl/tlb_tag_compare.sv
module tlb_tag_compare
    import tlb_pkg::*;
#(
    parameter int N = ENTRIES
) (
    input  entry_t [N-1:0]   ent,
    input  logic [PN_W-1:0]  va_pn,
    input  logic [TID_W-1:0] pid,
    output logic [N-1:0]     hit_vec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic tag_ok;
        logic pid_ok;
        assign tag_ok     = (((ent[g].vpn ^ va_pn) & ent[g].keep) == '0);
        assign pid_ok     = (ent[g].tid == '0) || (ent[g].tid == pid);
        assign hit_vec[g] = ent[g].valid & tag_ok & pid_ok;
    end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
    parameter int N     = tlb_pkg::ENTRIES,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     hit_vec,
    output logic             any,
    output logic             multi,
    output logic [IDX_W-1:0] index
);
    always_comb begin
        index = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) index = IDX_W'(i);
        end
    end

    assign any   = |hit_vec;
    assign multi = ((hit_vec & (hit_vec - 1'b1)) != '0);
endmodule

// File: rtl/assoc_xlat_tlb.sv
module assoc_xlat_tlb
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [TID_W-1:0]  lk_pid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [PN_W-1:0]   wr_vpn,
    input  logic [PN_W-1:0]   wr_ppn,
    input  logic [CODE_W-1:0] wr_size,
    input  logic [TID_W-1:0]  wr_tid,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              wr_prot,
    input  logic              inv_one,
    input  logic [IDX_W-1:0]  inv_index,
    input  logic              inv_all,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic              rs_multi,
    output logic [IDX_W-1:0]  rs_index,
    output logic [VA_W-1:0]   rs_paddr,
    output logic [PERM_W-1:0] rs_perm
);
    state_t st_d, st_q;

    logic [ENTRIES-1:0] hit_vec;
    logic               any_hit;
    logic               multi_hit;
    logic [IDX_W-1:0]   first_idx;
    logic               size_legal;
    logic [PN_W-1:0]    size_keep;
    logic [PN_W-1:0]    va_pn;
    logic [ENTRIES-1:0] vld_vec;
    logic [ENTRIES-1:0] prt_vec;
    entry_t             sel;

    assign va_pn = lk_vaddr[VA_W-1:PG_LSB];

    tlb_size_decode u_size (
        .code  (wr_size),
        .legal (size_legal),
        .keep  (size_keep)
    );

    tlb_tag_compare #(.N(ENTRIES)) u_cmp (
        .ent     (st_q.ent),
        .va_pn   (va_pn),
        .pid     (lk_pid),
        .hit_vec (hit_vec)
    );

    tlb_first_hit #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .hit_vec (hit_vec),
        .any     (any_hit),
        .multi   (multi_hit),
        .index   (first_idx)
    );

    assign sel = st_q.ent[first_idx];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flags
        assign vld_vec[g] = st_q.ent[g].valid;
        assign prt_vec[g] = st_q.ent[g].prot;
    end

    always_comb begin
        st_d = st_q;

        // lookup result, taken from the contents before this edge
        st_d.rs_valid = lk_valid;
        if (lk_valid && any_hit) begin
            st_d.rs_hit   = 1'b1;
            st_d.rs_multi = multi_hit;
            st_d.rs_index = first_idx;
            st_d.rs_perm  = sel.perm;
            st_d.rs_paddr = {(sel.ppn & sel.keep) | (va_pn & ~sel.keep),
                             lk_vaddr[PG_LSB-1:0]};
        end else begin
            st_d.rs_hit   = 1'b0;
            st_d.rs_multi = 1'b0;
            st_d.rs_index = '0;
            st_d.rs_perm  = '0;
            st_d.rs_paddr = '0;
        end

        // table maintenance: flush-all, then single invalidate, then write
        if (inv_all) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (!st_q.ent[i].prot) st_d.ent[i].valid = 1'b0;
            end
        end
        if (inv_one) st_d.ent[inv_index].valid = 1'b0;
        if (wr_en && size_legal) begin
            st_d.ent[wr_index].valid = 1'b1;
            st_d.ent[wr_index].prot  = wr_prot;
            st_d.ent[wr_index].tid   = wr_tid;
            st_d.ent[wr_index].vpn   = wr_vpn;
            st_d.ent[wr_index].ppn   = wr_ppn;
            st_d.ent[wr_index].keep  = size_keep;
            st_d.ent[wr_index].perm  = wr_perm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rs_valid = st_q.rs_valid;
    assign rs_hit   = st_q.rs_hit;
    assign rs_multi = st_q.rs_multi;
    assign rs_index = st_q.rs_index;
    assign rs_paddr = st_q.rs_paddr;
    assign rs_perm  = st_q.rs_perm;
endmodule

// File: rtl/assoc_xlat_tlb_checker.sv
module assoc_xlat_tlb_checker
    import tlb_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic               wr_en,
    input logic [IDX_W-1:0]   wr_index,
    input logic [CODE_W-1:0]  wr_size,
    input logic               inv_one,
    input logic               inv_all,
    input logic               rs_valid,
    input logic               rs_hit,
    input logic               rs_multi,
    input logic [IDX_W-1:0]   rs_index,
    input logic [VA_W-1:0]    rs_paddr,
    input logic [PERM_W-1:0]  rs_perm,
    input logic [ENTRIES-1:0] vld_vec,
    input logic [ENTRIES-1:0] prt_vec
);
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_result_follows_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (rs_valid == $past(lk_valid)));

    assert_hit_needs_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rs_hit |-> rs_valid);

    assert_miss_outputs_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_hit |-> (rs_paddr == '0 && rs_perm == '0 && rs_index == '0 && !rs_multi));

    assert_multi_implies_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rs_multi |-> rs_hit);

    assert_offset_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && rs_hit) |-> (rs_paddr[PG_LSB-1:0] == $past(lk_vaddr[PG_LSB-1:0])));

    assert_write_sets_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(wr_en && wr_size <= CODE_W'(MAX_CODE))) |-> vld_vec[$past(wr_index)]);

    assert_flush_keeps_protected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(inv_all && !wr_en && !inv_one))
            |-> (vld_vec == $past(vld_vec & prt_vec)));
endmodule

bind assoc_xlat_tlb assoc_xlat_tlb_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_vaddr (lk_vaddr),
    .wr_en    (wr_en),
    .wr_index (wr_index),
    .wr_size  (wr_size),
    .inv_one  (inv_one),
    .inv_all  (inv_all),
    .rs_valid (rs_valid),
    .rs_hit   (rs_hit),
    .rs_multi (rs_multi),
    .rs_index (rs_index),
    .rs_paddr (rs_paddr),
    .rs_perm  (rs_perm),
    .vld_vec  (vld_vec),
    .prt_vec  (prt_vec)
);

// File: tb/assoc_xlat_tlb_test.sv
module assoc_xlat_tlb_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_pid = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_index = '0;
    logic [19:0] wr_vpn = '0;
    logic [19:0] wr_ppn = '0;
    logic [3:0]  wr_size = '0;
    logic [7:0]  wr_tid = '0;
    logic [5:0]  wr_perm = '0;
    logic        wr_prot = 1'b0;
    logic        inv_one = 1'b0;
    logic [4:0]  inv_index = '0;
    logic        inv_all = 1'b0;
    logic        rs_valid, rs_hit, rs_multi;
    logic [4:0]  rs_index;
    logic [31:0] rs_paddr;
    logic [5:0]  rs_perm;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assoc_xlat_tlb uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
        .wr_en(wr_en), .wr_index(wr_index), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
        .wr_size(wr_size), .wr_tid(wr_tid), .wr_perm(wr_perm), .wr_prot(wr_prot),
        .inv_one(inv_one), .inv_index(inv_index), .inv_all(inv_all),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_multi(rs_multi),
        .rs_index(rs_index), .rs_paddr(rs_paddr), .rs_perm(rs_perm)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] va, input logic [31:0] pa,
                      input int code, input int tid, input int perm, input bit prot);
        @(negedge clk);
        wr_en = 1'b1; wr_index = 5'(idx); wr_vpn = va[31:12]; wr_ppn = pa[31:12];
        wr_size = 4'(code); wr_tid = 8'(tid); wr_perm = 6'(perm); wr_prot = prot;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input int pid);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_pid = 8'(pid);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_hit(input string tag, input logic [31:0] pa, input int idx,
                              input int perm, input bit multi);
        chk({tag, " hit"}, 32'(rs_hit), 32'd1);
        chk({tag, " paddr"}, rs_paddr, pa);
        chk({tag, " index"}, 32'(rs_index), 32'(idx));
        chk({tag, " perm"}, 32'(rs_perm), 32'(perm));
        chk({tag, " multi"}, 32'(rs_multi), 32'(multi));
    endtask

    task automatic expect_miss(input string tag);
        chk({tag, " hit"}, 32'(rs_hit), 32'd0);
        chk({tag, " paddr"}, rs_paddr, 32'd0);
        chk({tag, " perm"}, 32'(rs_perm), 32'd0);
        chk({tag, " index"}, 32'(rs_index), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 valid after reset", 32'(rs_valid), 32'd0);
        chk("R1 hit after reset", 32'(rs_hit), 32'd0);
        look(32'h0000_0000, 0);
        expect_miss("R1 empty lookup");
    endtask

    task automatic t_basic;
        wr(3, 32'h1234_5000, 32'hABCD_E000, 0, 5, 6'h15, 1'b0);
        look(32'h1234_5678, 5);
        chk("R2 result valid", 32'(rs_valid), 32'd1);
        expect_hit("R3 R12 basic", 32'hABCD_E678, 3, 6'h15, 1'b0);
        @(negedge clk);
        chk("R2 valid drops", 32'(rs_valid), 32'd0);
        look(32'h1234_6678, 5);
        expect_miss("R3 R7 other page");
        look(32'h1234_5678, 6);
        expect_miss("R6 wrong pid");
    endtask

    task automatic t_sizes;
        wr(7, 32'h3000_0000, 32'h5000_0000, 8, 0, 6'h01, 1'b0);
        look(32'h3ABC_DEF0, 9);
        expect_hit("R4 R6 256MB global", 32'h5ABC_DEF0, 7, 6'h01, 1'b0);
        wr(8, 32'h4560_0000, 32'h7890_0000, 4, 2, 6'h02, 1'b0);
        look(32'h456F_1234, 2);
        expect_hit("R4 1MB", 32'h789F_1234, 8, 6'h02, 1'b0);
        look(32'h4570_0000, 2);
        expect_miss("R4 1MB beyond");
        for (int c = 0; c <= 8; c++) begin
            logic [31:0] span;
            span = (32'd1 << (12 + 2*c)) - 32'd1;
            wr(10, 32'h8000_0000, 32'h4000_0000, c, 0, 6'h3F, 1'b0);
            look(32'h8000_0000 | span, 1);
            expect_hit($sformatf("R4 code %0d top", c), 32'h4000_0000 | span, 10, 6'h3F, 1'b0);
            look(32'h8000_0000 + span + 32'd1, 1);
            expect_miss($sformatf("R4 code %0d next page", c));
        end
    endtask

    task automatic t_illegal;
        wr(3, 32'h1234_5000, 32'h0EEE_E000, 9, 5, 6'h0A, 1'b0);
        look(32'h1234_5678, 5);
        expect_hit("R5 code 9 ignored", 32'hABCD_E678, 3, 6'h15, 1'b0);
        wr(3, 32'h1234_5000, 32'h0EEE_E000, 15, 5, 6'h0A, 1'b0);
        look(32'h1234_5678, 5);
        expect_hit("R5 code 15 ignored", 32'hABCD_E678, 3, 6'h15, 1'b0);
    endtask

    task automatic t_multi;
        wr(20, 32'h1234_5000, 32'h1111_1000, 0, 0, 6'h07, 1'b0);
        look(32'h1234_5678, 5);
        expect_hit("R8 overlap lowest", 32'hABCD_E678, 3, 6'h15, 1'b1);
        @(negedge clk);
        inv_one = 1'b1; inv_index = 5'd3;
        @(negedge clk);
        inv_one = 1'b0;
        look(32'h1234_5678, 5);
        expect_hit("R8 R10 after invalidate", 32'h1111_1678, 20, 6'h07, 1'b0);
    endtask

    task automatic t_flush;
        wr(25, 32'h6000_0000, 32'h2000_0000, 0, 0, 6'h11, 1'b1);
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        look(32'h6000_0abc, 4);
        expect_hit("R9 protected kept", 32'h2000_0abc, 25, 6'h11, 1'b0);
        look(32'h3ABC_DEF0, 9);
        expect_miss("R9 unprotected gone");
        look(32'h1234_5678, 5);
        expect_miss("R9 entry 20 gone");
        @(negedge clk);
        inv_one = 1'b1; inv_index = 5'd25;
        @(negedge clk);
        inv_one = 1'b0;
        look(32'h6000_0abc, 4);
        expect_miss("R10 protected invalidated");
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        wr_en = 1'b1; wr_index = 5'd12; wr_vpn = 20'hCAFE0; wr_ppn = 20'h0BEEF;
        wr_size = 4'd0; wr_tid = 8'd0; wr_perm = 6'h2A; wr_prot = 1'b0;
        lk_valid = 1'b1; lk_vaddr = 32'hCAFE_0123; lk_pid = 8'd3;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        expect_miss("R2 R11 lookup sees old table");
        look(32'hCAFE_0123, 3);
        expect_hit("R11 write visible next", 32'h0BEE_F123, 12, 6'h2A, 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_index = 5'd13; wr_vpn = 20'hD0000; wr_ppn = 20'h00123;
        wr_size = 4'd0; wr_tid = 8'd0; wr_perm = 6'h05; wr_prot = 1'b0;
        inv_one = 1'b1; inv_index = 5'd13; inv_all = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; inv_one = 1'b0; inv_all = 1'b0;
        look(32'hD000_0456, 7);
        expect_hit("R11 write beats invalidates", 32'h0012_3456, 13, 6'h05, 1'b0);
        look(32'hCAFE_0123, 3);
        expect_miss("R11 flush applied to others");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_sizes();
        t_illegal();
        t_multi();
        t_flush();
        t_same_cycle();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule